// File: doc/BRIEF.md
# Power-Down and Clock-Stabilization Sequencer

This block decides when a small 8-bit controller's oscillator and CPU clock may run. From run mode, software can request idle or stop. Idle gates only the CPU clock. Stop halts the oscillator as well. An external-interrupt wake signal leaves idle at once. It leaves stop through a stabilization wait, and the CPU clock stays gated until that wait is over. A low-voltage flag or a held-low reset pin puts the part into a back-up state with the oscillator blocked. Leaving back-up, like a block reset, goes through a long fixed wait.

One 8-bit basic timer, fed by a prescaler with four divide ratios, does two jobs. During a wait it is the stabilization counter. In run and idle it is a watchdog: an overflow without a clear gives a one-cycle system-reset pulse. The wait after a reset or after back-up is 16 counts at the slowest ratio, which is 65536 oscillator cycles by default. The wait after an interrupt wake is a full 256-count pass at the ratio chosen by the control field.

Top module: `pd_sequencer`

## Requirements
- R1: While `rst` is high and right after it, `mode` is WAIT (3), `osc_en` is 1, `cpu_clk_en` is 0 and `sys_rst_pulse` is 0. The reset-type wait then lasts exactly RST_TICKS·2^PRE_W cycles (65536 by default) before RUN. Asserting `rst` in any state restarts this wait from zero.
- R2: A `stop_req` in RUN enters STOP (2) on the next edge, with `osc_en` and `cpu_clk_en` both 0. In STOP the basic timer is frozen, so no watchdog pulse appears however long the block stays there. When `stop_req` and `idle_req` arrive together, STOP wins.
- R3: An `idle_req` in RUN enters IDLE (1), with `osc_en` 1 and `cpu_clk_en` 0. The basic timer keeps counting in IDLE. A `wake_irq` in IDLE returns to RUN on the next edge.
- R4: A `wake_irq` in STOP enters WAIT. That wait lasts exactly 256·D cycles. D is taken from `wait_sel` at the wake edge and is held for the whole wait: code 0 gives 2^PRE_W, 1 gives 2^(PRE_W-2), 2 gives 2^(PRE_W-5) and 3 gives 2^(PRE_W-8) (4096/1024/128/16 by default).
- R5: `wake_irq`, `stop_req` and `idle_req` are ignored during a WAIT, and the wait length does not change.
- R6: `lvd_flag` or `pin_low` high enters BACKUP (4) from any state on the next edge, with `osc_en` and `cpu_clk_en` both 0.
- R7: With `lvd_stop_en` = 0, `lvd_flag` does not take the block out of STOP. `pin_low` still enters BACKUP, and `lvd_flag` is honoured in BACKUP.
- R8: When both `lvd_flag` and `pin_low` are low in BACKUP, the block enters the reset-type wait of R1. This also applies when BACKUP interrupted an interrupt-type wait.
- R9: In RUN and IDLE, 256·D(`wait_sel`) cycles after the timer was last cleared, `sys_rst_pulse` is high for exactly one cycle.
- R10: `wdt_clr` in RUN clears the prescaler and the counter on the next edge. Clearing more often than once per overflow period keeps `sys_rst_pulse` low.
- R11: `mode` encodes RUN=0, IDLE=1, STOP=2, WAIT=3 and BACKUP=4. `cpu_clk_en` is 1 only in RUN. `osc_en` is 0 only in STOP and BACKUP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| stop_req | input | 1 | Stop request from the CPU |
| idle_req | input | 1 | Idle request from the CPU |
| wake_irq | input | 1 | External-interrupt wake event |
| pin_low | input | 1 | Reset pin held low, already synchronized |
| lvd_flag | input | 1 | Low-voltage-detect flag |
| lvd_stop_en | input | 1 | Allows the voltage flag to enter back-up from stop |
| wait_sel | input | 2 | Prescaler ratio select from the timer control field |
| wdt_clr | input | 1 | Watchdog clear strobe |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_rst_pulse | output | 1 | One-cycle watchdog system reset |
| mode | output | 3 | Current mode code |

## Verification
A wrong prescaler tap or a wrong counter limit shows up as a wait length or a watchdog period that is off by a whole multiple of a ratio. The bench therefore counts every wait and every period to the exact cycle for each ratio. It uses a small prescaler so that these counts stay short. A timer that keeps running in stop appears as a spurious reset pulse within one 256-cycle period. A mishandled wake or request during a wait changes the counted wait length, and a wrong state transition shows on `mode` one edge after the stimulus.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [2:0] {
        MODE_RUN    = 3'd0,
        MODE_IDLE   = 3'd1,
        MODE_STOP   = 3'd2,
        MODE_WAIT   = 3'd3,
        MODE_BACKUP = 3'd4
    } pd_mode_e;

    typedef enum logic {
        WAIT_FROM_RESET = 1'b0,
        WAIT_FROM_IRQ   = 1'b1
    } pd_wait_e;

    // Right shift applied to the full prescaler length for each select code.
    function automatic int ratio_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 5;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/pd_prescaler.sv
module pd_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] ratio,
    output logic       tick
);
    import pd_pkg::*;

    logic [PRE_W-1:0] pre_q;
    logic [3:0]       tap;

    // One tap per ratio: high on the last cycle of each divide period.
    for (genvar g = 0; g < 4; g++) begin : g_tap
        localparam int LG = PRE_W - ratio_shift(2'(g));
        if (LG == 0) begin : g_every
            assign tap[g] = 1'b1;
        end else begin : g_div
            assign tap[g] = &pre_q[LG-1:0];
        end
    end

    assign tick = run && tap[ratio];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pd_tick_counter.sv
module pd_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign wrap = tick && (cnt_q == CNT_MAX);

endmodule

// File: rtl/pd_mode_fsm.sv
module pd_mode_fsm #(
    parameter int CNT_W     = 8,
    parameter int RST_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req,
    input  logic             idle_req,
    input  logic             wake_irq,
    input  logic             pin_low,
    input  logic             lvd_flag,
    input  logic             lvd_stop_en,
    input  logic [1:0]       wait_sel,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    output pd_pkg::pd_mode_e state,
    output logic [1:0]       ratio,
    output logic             run,
    output logic             timer_clr
);
    import pd_pkg::*;

    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_TICKS - 1);
    localparam logic [CNT_W-1:0] IRQ_LAST = {CNT_W{1'b1}};

    pd_mode_e   st_q, st_d;
    pd_wait_e   kind_q, kind_d;
    logic [1:0] sel_q, sel_d;
    logic       backup_cond;
    logic       wait_done;

    assign backup_cond = pin_low ||
                         (lvd_flag && !(st_q == MODE_STOP && !lvd_stop_en));
    assign wait_done   = tick &&
                         (cnt == ((kind_q == WAIT_FROM_RESET) ? RST_LAST : IRQ_LAST));

    always_comb begin
        st_d   = st_q;
        kind_d = kind_q;
        sel_d  = sel_q;
        if (backup_cond) begin
            st_d = MODE_BACKUP;
        end else begin
            case (st_q)
                MODE_RUN: begin
                    if (stop_req)      st_d = MODE_STOP;
                    else if (idle_req) st_d = MODE_IDLE;
                end
                MODE_IDLE: begin
                    if (wake_irq) st_d = MODE_RUN;
                end
                MODE_STOP: begin
                    if (wake_irq) begin
                        st_d   = MODE_WAIT;
                        kind_d = WAIT_FROM_IRQ;
                        sel_d  = wait_sel;
                    end
                end
                MODE_WAIT: begin
                    if (wait_done) st_d = MODE_RUN;
                end
                default: begin
                    st_d   = MODE_WAIT;
                    kind_d = WAIT_FROM_RESET;
                end
            endcase
        end
    end

    // The timer restarts on entry to a wait or back-up and on leaving a wait.
    assign timer_clr = (st_d != st_q) &&
                       (st_d == MODE_WAIT || st_d == MODE_BACKUP || st_q == MODE_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= MODE_WAIT;
            kind_q <= WAIT_FROM_RESET;
            sel_q  <= 2'd0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            sel_q  <= sel_d;
        end
    end

    assign state = st_q;
    assign run   = (st_q == MODE_RUN) || (st_q == MODE_IDLE) || (st_q == MODE_WAIT);
    assign ratio = (st_q != MODE_WAIT)          ? wait_sel :
                   (kind_q == WAIT_FROM_RESET)  ? 2'd0     : sel_q;

    // R5
    wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == MODE_WAIT) |=> (st_q == MODE_WAIT || st_q == MODE_RUN || st_q == MODE_BACKUP));

    // R7
    lvd_stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == MODE_STOP && !lvd_stop_en && !pin_low && !wake_irq) |=> (st_q == MODE_STOP));

    // R4
    stop_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == MODE_STOP && wake_irq && !pin_low && !(lvd_flag && lvd_stop_en))
        |=> (st_q == MODE_WAIT));

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
    parameter int CNT_W     = 8,
    parameter int PRE_W     = 12,
    parameter int RST_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       idle_req,
    input  logic       wake_irq,
    input  logic       pin_low,
    input  logic       lvd_flag,
    input  logic       lvd_stop_en,
    input  logic [1:0] wait_sel,
    input  logic       wdt_clr,
    output logic       osc_en,
    output logic       cpu_clk_en,
    output logic       sys_rst_pulse,
    output logic [2:0] mode
);
    import pd_pkg::*;

    pd_mode_e         state;
    logic [1:0]       ratio;
    logic             run, fsm_clr, clr, tick, wrap;
    logic [CNT_W-1:0] cnt;
    logic             wdt_q;

    pd_mode_fsm #(.CNT_W(CNT_W), .RST_TICKS(RST_TICKS)) u_fsm (
        .clk(clk), .rst(rst), .stop_req(stop_req), .idle_req(idle_req),
        .wake_irq(wake_irq), .pin_low(pin_low), .lvd_flag(lvd_flag),
        .lvd_stop_en(lvd_stop_en), .wait_sel(wait_sel), .tick(tick), .cnt(cnt),
        .state(state), .ratio(ratio), .run(run), .timer_clr(fsm_clr)
    );

    // Software can clear the watchdog only while the CPU clock runs.
    assign clr = fsm_clr || (wdt_clr && state == MODE_RUN);

    pd_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .run(run), .clr(clr), .ratio(ratio), .tick(tick)
    );

    pd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .tick(tick), .cnt(cnt), .wrap(wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_q <= 1'b0;
        end else begin
            wdt_q <= wrap && (state == MODE_RUN || state == MODE_IDLE);
        end
    end

    assign sys_rst_pulse = wdt_q;
    assign mode          = state;
    assign cpu_clk_en    = (state == MODE_RUN);
    assign osc_en        = !(state == MODE_STOP || state == MODE_BACKUP);

    // R2
    stop_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_STOP && $past(state == MODE_STOP)) |-> $stable(cnt));

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |=> !sys_rst_pulse);

    // R6
    backup_idle_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (state == MODE_BACKUP) |-> (cnt == '0));

    // R10
    clear_applied_chk: assert property (@(posedge clk) disable iff (rst)
        (wdt_clr && state == MODE_RUN) |=> (cnt == '0));

endmodule

// File: tb/tb_pd_sequencer.sv
module tb_pd_sequencer;

    localparam int PRE_W = 8;
    localparam int RSTW  = 16 * (1 << PRE_W);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_req = 0, idle_req = 0, wake_irq = 0, pin_low = 0, lvd_flag = 0;
    logic       lvd_stop_en = 1'b1;
    logic [1:0] wait_sel = 2'd3;
    logic       wdt_clr = 0;
    logic       osc_en, cpu_clk_en, sys_rst_pulse;
    logic [2:0] mode;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pd_sequencer #(.PRE_W(PRE_W)) dut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .idle_req(idle_req),
        .wake_irq(wake_irq), .pin_low(pin_low), .lvd_flag(lvd_flag),
        .lvd_stop_en(lvd_stop_en), .wait_sel(wait_sel), .wdt_clr(wdt_clr),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .sys_rst_pulse(sys_rst_pulse),
        .mode(mode)
    );

    function automatic int div_of(input int sel);
        int sh [4] = '{0, 2, 5, 8};
        return 1 << (PRE_W - sh[sel]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input int m, input int osc, input int cpu);
        check({tag, " mode"}, int'(mode), m);
        check({tag, " osc_en"}, int'(osc_en), osc);
        check({tag, " cpu_clk_en"}, int'(cpu_clk_en), cpu);
    endtask

    // Counts negedges with mode WAIT, starting at the current one.
    task automatic wait_len(output int n);
        n = 0;
        while (mode == 3'd3 && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    // Counts from a watchdog clear to the reset pulse.
    task automatic wdt_period(output int n);
        wdt_clr = 1'b1;
        @(negedge clk);
        wdt_clr = 1'b0;
        n = 0;
        while (!sys_rst_pulse && n < 70000) begin
            n++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        check_outs("R1 reset", 3, 1, 0);
        check("R1 reset pulse", int'(sys_rst_pulse), 0);
        rst = 1'b0;
        wait_len(n);
        check("R1 reset wait length", n, RSTW);
        check_outs("R11 run", 0, 1, 1);

        // Watchdog from entry into RUN, ratio code 3
        n = 0;
        while (!sys_rst_pulse && n < 70000) begin
            n++;
            @(negedge clk);
        end
        check("R9 overflow sel3", n, 256 * div_of(3));
        @(negedge clk);
        check("R9 pulse width", int'(sys_rst_pulse), 0);

        // R10: regular clears keep the pulse away
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            pulse(wdt_clr);
            for (int j = 0; j < 200; j++) begin
                if (sys_rst_pulse) seen = 1;
                @(negedge clk);
            end
        end
        check("R10 no pulse while cleared", int'(seen), 0);
        wait_sel = 2'd2;
        wdt_period(n);
        check("R9 overflow sel2", n, 256 * div_of(2));
        wait_sel = 2'd3;

        // R3: idle keeps the timer running
        wdt_clr = 1'b1;
        @(negedge clk);
        wdt_clr = 1'b0;
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        n = 1;
        check_outs("R3 idle", 1, 1, 0);
        while (!sys_rst_pulse && n < 70000) begin
            n++;
            @(negedge clk);
        end
        check("R3 timer runs in idle", n, 256);
        pulse(wake_irq);
        check_outs("R3 idle wake", 0, 1, 1);

        // R2: stop wins over idle, timer frozen
        stop_req = 1'b1;
        idle_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        idle_req = 1'b0;
        check_outs("R2 stop", 2, 0, 0);
        seen = 0;
        for (int j = 0; j < 1000; j++) begin
            if (sys_rst_pulse || mode != 3'd2) seen = 1;
            @(negedge clk);
        end
        check("R2 frozen in stop", int'(seen), 0);
        pulse(wake_irq);
        wait_len(n);
        check("R4 wake wait sel3", n, 256 * div_of(3));

        // R4: ratio latched at the wake edge
        pulse(stop_req);
        wait_sel = 2'd2;
        pulse(wake_irq);
        wait_sel = 2'd3;
        wait_len(n);
        check("R4 wake wait sel2 latched", n, 256 * div_of(2));
        pulse(stop_req);
        wait_sel = 2'd1;
        pulse(wake_irq);
        wait_sel = 2'd3;
        wait_len(n);
        check("R4 wake wait sel1", n, 256 * div_of(1));

        // R5: requests during the wait are ignored
        pulse(stop_req);
        wait_sel = 2'd2;
        pulse(wake_irq);
        wait_sel = 2'd3;
        n = 0;
        while (mode == 3'd3 && n < 70000) begin
            if (n == 100) begin wake_irq = 1; stop_req = 1; idle_req = 1; end
            if (n == 101) begin wake_irq = 0; stop_req = 0; idle_req = 0; end
            n++;
            @(negedge clk);
        end
        check("R5 wait length unchanged", n, 256 * div_of(2));
        check("R5 mode after wait", int'(mode), 0);

        // R6/R8: voltage flag from RUN
        lvd_flag = 1'b1;
        @(negedge clk);
        check_outs("R6 lvd backup", 4, 0, 0);
        repeat (50) @(negedge clk);
        check("R6 backup held", int'(mode), 4);
        lvd_flag = 1'b0;
        @(negedge clk);
        wait_len(n);
        check("R8 backup exit wait", n, RSTW);

        // R6/R8: pin low during an interrupt wait
        pulse(stop_req);
        wait_sel = 2'd1;
        pulse(wake_irq);
        wait_sel = 2'd3;
        repeat (500) @(negedge clk);
        pin_low = 1'b1;
        @(negedge clk);
        check_outs("R6 pin backup in wait", 4, 0, 0);
        pin_low = 1'b0;
        @(negedge clk);
        wait_len(n);
        check("R8 restart reset wait", n, RSTW);

        // R7: flag masked in stop
        lvd_stop_en = 1'b0;
        pulse(stop_req);
        lvd_flag = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 stop holds with lvd", int'(mode), 2);
        pin_low = 1'b1;
        @(negedge clk);
        check("R7 pin low in stop", int'(mode), 4);
        pin_low = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 lvd honoured in backup", int'(mode), 4);
        lvd_flag = 1'b0;
        @(negedge clk);
        wait_len(n);
        check("R8 exit after masked stop", n, RSTW);

        // R6: flag enabled in stop
        lvd_stop_en = 1'b1;
        pulse(stop_req);
        lvd_flag = 1'b1;
        @(negedge clk);
        check("R6 lvd from stop", int'(mode), 4);
        lvd_flag = 1'b0;
        @(negedge clk);
        wait_len(n);

        // R1: reset during an interrupt wait
        pulse(stop_req);
        wait_sel = 2'd1;
        pulse(wake_irq);
        wait_sel = 2'd3;
        repeat (300) @(negedge clk);
        pulse(rst);
        check("R1 reset in wait mode", int'(mode), 3);
        wait_len(n);
        check("R1 reset restarts wait", n, RSTW);
        check_outs("R11 final run", 0, 1, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule